// File: doc/BRIEF.md
# Byte-Lane Write Decode and Pipelined Data Path for a Synchronous Burst SRAM

This block sits between the pin-side controls of a 36-bit synchronous burst SRAM and its storage. The storage is four 9-bit byte lanes. Each clock edge, the block captures three things:

- the select qualifiers;
- the write controls;
- the address, which a separate burst sequencer supplies.

A selected cycle becomes either a write, which strobes one or more lanes, or a read. A deselected cycle is idle.

Both data directions are registered.

- **Write data:** the incoming word is held in an input register for one cycle. It is committed to the lane memories at the following edge.
- **Read data:** a read launched at one edge is loaded into the output register at the next edge.

The data-bus drivers are enabled only while the output register holds read data and the output enable is low. The output enable works without waiting for a clock edge. Any write cycle turns the drivers off.

Write requests follow a fixed priority:

1. A low global write strobes every lane.
2. Otherwise, a low byte-write gate passes the four per-lane enables through.
3. With the gate high, the per-lane enables have no effect.

Top module: `sram_lane_ctrl`

## Requirements
- R1: If the chip is selected and `gwr_n` is low at an edge, `lane_stb` is all ones from that edge to the next, whatever `bgate_n` and `lane_wr_n` are.
- R2: If selected, with `gwr_n` high and `bgate_n` low, `lane_stb[i]` is the inverse of `lane_wr_n[i]` in the following cycle.
- R3: If selected, with `gwr_n` high and `bgate_n` high, `lane_stb` is zero in the following cycle, and the cycle is a read.
- R4: Lane i covers data bits 9*i to 9*i+8. A write commits only the lanes whose strobe is set, and the other lanes of that word keep their old contents.
- R5: The chip is selected only when `en_n` is 0, `sel_hi` is 1 and `sel_lo_n` is 0, all sampled at the edge.
- R6: A cycle that is not selected raises no strobe. After the next edge `drive_en` is 0 and `rd_data` keeps its previous value.
- R7: A cycle with any lane strobe set forces `drive_en` to 0 after the following edge.
- R8: `drive_en` equals (read data valid AND NOT `oe_n`), and it follows `oe_n` with no clock edge in between.
- R9: A selected read captured at edge k puts the addressed word on `rd_data` after edge k+1. That word includes any write whose strobes were raised at edge k-1 or earlier.
- R10: A synchronous active-high `rst` clears `lane_stb`, `rd_data` and `drive_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address from the burst sequencer |
| gwr_n | input | 1 | Global write, active low |
| bgate_n | input | 1 | Byte-write gate, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| en_n | input | 1 | Chip enable, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| dq_in | input | LANES*LANE_W | Write data |
| lane_stb | output | LANES | Registered per-lane write strobes |
| rd_data | output | LANES*LANE_W | Registered read data |
| drive_en | output | 1 | Tri-state driver enable for the data bus |

## Verification
A mistake in the write priority decode shows up on `lane_stb` in the cycle right after the stimulus. If a wrong lane was committed, it shows up on `rd_data` two edges after the next read of that address, as a 9-bit field that is either wrong or unchanged when it should have changed. An error in the valid flag or the select logic shows up as `drive_en` asserted after a write or a deselected cycle, or as a held `rd_data` value that changed. The output-enable path is checked one nanosecond after `oe_n` moves, with no clock edge in between.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/wr_prio_decode.sv
module wr_prio_decode #(
  parameter int LANES = 4
) (
  input  logic             gwr_n,
  input  logic             bgate_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             en_n,
  input  logic             sel_hi,
  input  logic             sel_lo_n,
  output logic             chip_sel,
  output logic [LANES-1:0] wr_mask
);
  logic global_wr;
  logic gate_open;

  always_comb begin
    chip_sel  = !en_n && sel_hi && !sel_lo_n;
    global_wr = !gwr_n;
    gate_open = !bgate_n;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (!chip_sel)      wr_mask[g] = 1'b0;
      else if (global_wr) wr_mask[g] = 1'b1;
      else if (gate_open) wr_mask[g] = !lane_wr_n[g];
      else                wr_mask[g] = 1'b0;
    end
  end
endmodule

// File: rtl/lane_bank.sv
module lane_bank #(
  parameter int W  = 9,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    gwr_n,
  input  logic                    bgate_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    en_n,
  input  logic                    sel_hi,
  input  logic                    sel_lo_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES-1:0]        lane_stb,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    drive_en
);
  localparam int DW = LANES * LANE_W;

  logic             chip_sel;
  logic [LANES-1:0] wr_mask;
  op_e              s1_op;
  logic [LANES-1:0] s1_mask;
  logic [ADDR_W-1:0] s1_addr;
  logic [DW-1:0]    s1_data;
  logic             rd_vld;

  wr_prio_decode #(.LANES(LANES)) dec_i (
    .gwr_n    (gwr_n),
    .bgate_n  (bgate_n),
    .lane_wr_n(lane_wr_n),
    .en_n     (en_n),
    .sel_hi   (sel_hi),
    .sel_lo_n (sel_lo_n),
    .chip_sel (chip_sel),
    .wr_mask  (wr_mask)
  );

  // Input stage: controls, address and write data registered together.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op   <= OP_IDLE;
      s1_mask <= '0;
      s1_addr <= '0;
      s1_data <= '0;
    end else begin
      s1_mask <= wr_mask;
      s1_addr <= addr;
      s1_data <= dq_in;
      if (!chip_sel)        s1_op <= OP_IDLE;
      else if (|wr_mask)    s1_op <= OP_WRITE;
      else                  s1_op <= OP_READ;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    lane_bank #(.W(LANE_W), .AW(ADDR_W)) bank_i (
      .clk  (clk),
      .rst  (rst),
      .we   (s1_mask[g]),
      .re   (s1_op == OP_READ),
      .addr (s1_addr),
      .wdata(s1_data[g*LANE_W +: LANE_W]),
      .rdata(rd_data[g*LANE_W +: LANE_W])
    );
  end

  // Output stage valid flag: set only by a completed read.
  always_ff @(posedge clk) begin
    if (rst) rd_vld <= 1'b0;
    else     rd_vld <= (s1_op == OP_READ);
  end

  assign lane_stb = s1_mask;
  assign drive_en = rd_vld && !oe_n;

  // R1
  gw_all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (chip_sel && !gwr_n) |=> (lane_stb == '1));

  // R3
  gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (chip_sel && gwr_n && bgate_n) |=> (lane_stb == '0));

  // R6
  desel_no_stb_chk: assert property (@(posedge clk) disable iff (rst)
    (!chip_sel) |=> (lane_stb == '0));

  // R7
  wr_blocks_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_stb != '0) |=> !drive_en);

  // R6
  desel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_op == OP_IDLE) |=> $stable(rd_data));

  // R8
  always_comb begin
    oe_gate_chk: assert (!(drive_en && oe_n));
  end
endmodule

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;
  localparam int LANES = 4;
  localparam int LW    = 9;
  localparam int AW    = 6;
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic gwr_n = 1'b1, bgate_n = 1'b1, en_n = 1'b1, sel_hi = 1'b0, sel_lo_n = 1'b1, oe_n = 1'b1;
  logic [LANES-1:0] lane_wr_n = '1;
  logic [DW-1:0] dq_in = '0;
  logic [LANES-1:0] lane_stb;
  logic [DW-1:0] rd_data;
  logic drive_en;

  always #5 clk = ~clk;

  sram_lane_ctrl #(.LANES(LANES), .LANE_W(LW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .gwr_n(gwr_n), .bgate_n(bgate_n),
    .lane_wr_n(lane_wr_n), .en_n(en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .oe_n(oe_n), .dq_in(dq_in), .lane_stb(lane_stb), .rd_data(rd_data),
    .drive_en(drive_en)
  );

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  // model: 0 idle, 1 read, 2 write
  logic [DW-1:0] mem_m [DEPTH];
  int p_op = 0, c_op = 0;
  logic [LANES-1:0] p_mask = '0, c_mask = '0;
  logic [AW-1:0] p_addr = '0, c_addr = '0;
  logic [DW-1:0] p_data = '0, c_data = '0;
  string c_tag = "R6";
  logic exp_vld = 1'b0;
  logic [DW-1:0] exp_rd = '0;
  string vld_tag = "R10";

  function automatic logic f_sel(logic ce, logic c0, logic c1);
    return !ce && c0 && !c1;
  endfunction

  function automatic logic [LANES-1:0] f_mask(logic s, logic gw, logic bg, logic [LANES-1:0] ln);
    if (!s) return '0;
    if (!gw) return '1;
    if (!bg) return ~ln;
    return '0;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(logic gw, logic bg, logic [LANES-1:0] ln, logic ce, logic c0,
                     logic c1, logic oe, logic [AW-1:0] a, logic [DW-1:0] d);
    logic s;
    gwr_n = gw; bgate_n = bg; lane_wr_n = ln; en_n = ce; sel_hi = c0;
    sel_lo_n = c1; oe_n = oe; addr = a; dq_in = d;
    s = f_sel(ce, c0, c1);
    c_mask = f_mask(s, gw, bg, ln);
    c_op = !s ? 0 : (c_mask != '0) ? 2 : 1;
    c_addr = a; c_data = d;
    c_tag = !s ? "R5" : !gw ? "R1" : bg ? "R3" : "R2";
    #1;
    // R8: oe_n acts without a clock edge
    chk("R8", DW'(drive_en), DW'(exp_vld && !oe));
    @(negedge clk);
    if (p_op == 2) begin
      for (int i = 0; i < LANES; i++)
        if (p_mask[i]) mem_m[p_addr][i*LW +: LW] = p_data[i*LW +: LW];
      exp_vld = 1'b0; vld_tag = "R7";
    end else if (p_op == 1) begin
      exp_rd = mem_m[p_addr]; exp_vld = 1'b1; vld_tag = "R9";
    end else begin
      exp_vld = 1'b0; vld_tag = "R6";
    end
    p_op = c_op; p_mask = c_mask; p_addr = c_addr; p_data = c_data;
    chk(c_tag, DW'(lane_stb), DW'(c_mask));
    chk(vld_tag, DW'(drive_en), DW'(exp_vld && !oe_n));
    chk(exp_vld ? "R4" : "R6", rd_data, exp_rd);
  endtask

  function automatic logic [DW-1:0] rnd_d();
    return {4'($urandom), 32'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10", DW'(lane_stb), '0);
    chk("R10", rd_data, '0);
    chk("R10", DW'(drive_en), '0);
    // Preload every address with a global write
    for (int a = 0; a < DEPTH; a++)
      cyc(1'b0, 1'($urandom), 4'($urandom), 1'b0, 1'b1, 1'b0, 1'($urandom), AW'(a), rnd_d());
    // R1: global write overrides a gate with lanes off
    cyc(1'b0, 1'b0, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 6'd5, rnd_d());
    cyc(1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 6'd5, '0);
    cyc(1'b1, 1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 6'd5, '0);
    // R3: gate high, all lanes requested -> read
    cyc(1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd9, rnd_d());
    // R4: each single lane, followed by a read back
    for (int i = 0; i < LANES; i++) begin
      cyc(1'b1, 1'b0, ~(4'b1 << i), 1'b0, 1'b1, 1'b0, 1'b0, 6'd12, rnd_d());
      cyc(1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 6'd12, '0);
    end
    cyc(1'b1, 1'b1, 4'hF, 1'b1, 1'b0, 1'b1, 1'b0, 6'd0, '0);
    // R5: each select qualifier wrong blocks a global write
    cyc(1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd20, rnd_d());
    cyc(1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd20, rnd_d());
    cyc(1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd20, rnd_d());
    cyc(1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 6'd20, '0);
    cyc(1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, 6'd20, '0);
    // Constrained random traffic
    for (int k = 0; k < 3000; k++)
      cyc(($urandom % 5) != 0, ($urandom % 2) != 0, 4'($urandom),
          ($urandom % 8) == 0, ($urandom % 8) != 0, ($urandom % 8) == 0,
          ($urandom % 4) == 0, AW'($urandom), rnd_d());
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule